// File: doc/BRIEF.md
# Dual-Processor Address Region Decoder

This block sits between two processors and the memories and register windows they share. Each processor sends a request made of a 32-bit address, a size (byte, halfword or word), a direction and write data, together with a one-bit processor identity. The block registers the request. It then decodes it without further registers into a one-hot target select, a masked local offset, the size of the access and an unmapped flag. The targets are these: a boot ROM for each processor, a system register window, a video register window, palette RAM, cartridge ROM, frame buffer, SDRAM, a data array for each processor, and a peripheral window.

The coarse region comes from five address bits: the top three bits and the two chip-select bits. Chip-select 0 is decoded a second time, on finer bits, into the register windows and the boot ROM. All storage except the peripheral window is organised in halfwords. A word access to any such target leaves the block as two halfword beats on consecutive cycles, and the port that accepts requests is held off during the first beat. For reads, the block gives back the target's data, or zero when the access is unmapped.

Top module: `rgn_bus_decoder`

## Requirements
- R1: The region index is {addr[31:29], addr[26:25]}. Indices 1 and 5 select cartridge ROM (acc_sel bit 5) with offset addr & 0x3FFFFF. Indices 2 and 6 select the frame buffer (bit 6) with offset addr & 0x1FFFF. Indices 3 and 7 select SDRAM (bit 7) with offset addr & 0x3FFFF. Both indices of each pair behave the same.
- R2: Index 0x18 selects the data array of the requester: bit 8 for processor 0 and bit 9 for processor 1. The offset is addr[11:0].
- R3: Indices 0 and 4 (chip-select 0) compare addr[17:8]. The value 0x40 selects system registers (bit 2, offset addr[7:0]). The value 0x41 selects video registers (bit 3, offset addr[7:0]). The value 0x42 selects palette (bit 4, offset addr[8:0]). A palette write compares only addr[17:9] against 0x21, so a write to 0x43xx also reaches palette, while a read of 0x43xx does not.
- R4: Inside chip-select 0, addr[28:0] below BOOT_BYTES (2048 by default) selects the boot ROM of the requester: bit 0 for processor 0 and bit 1 for processor 1. The offset is the address masked to the ROM size. The value 2048 itself does not select the boot ROM.
- R5: An unassigned index, or a chip-select-0 address that matches no window, is unmapped. acc_sel is all zero, acc_offset is zero, acc_unmapped is high, and rsp_data is zero whatever tgt_rdata holds. For mapped reads, rsp_data equals tgt_rdata.
- R6: Size codes are 0 for byte, 1 for halfword and 2 for word. A byte access to a halfword-organised target inverts offset bit 0. A halfword access clears offset bit 0. Peripheral offsets are left unchanged.
- R7: A word access to any region except 0x1F becomes two beats, both of size 1. The first beat uses the original address and carries wdata[31:16] on acc_wdata[15:0]. The second beat uses address+2 and carries wdata[15:0].
- R8: acc_busy is high during both beats of a split access. req_ready is low during the first beat, so a request held during that beat is taken only at the end of the second beat.
- R9: Index 0x1F selects the peripheral window (bit 10) with offset addr[8:0]. A word access there is one beat of size 2 carrying the full write data.
- R10: A request taken at a clock edge appears on the access outputs from that edge on. A single-beat access stays valid for one cycle only, unless another request follows.
- R11: In reset, and afterwards until a request arrives, acc_valid, acc_busy and acc_unmapped are low, acc_sel is zero and req_ready is high. At most one acc_sel bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_cpu | input | 1 | Requester identity |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| acc_valid | output | 1 | Access beat present |
| acc_cpu | output | 1 | Requester of the current beat |
| acc_write | output | 1 | Direction of the current beat |
| acc_size | output | 2 | Size of the current beat |
| acc_sel | output | 11 | One-hot target select |
| acc_offset | output | 22 | Masked local byte offset |
| acc_wdata | output | 32 | Write data of the current beat |
| acc_unmapped | output | 1 | Beat hits no target |
| acc_busy | output | 1 | Split word access in progress |
| tgt_rdata | input | 32 | Read data from the selected target |
| rsp_data | output | 32 | Read data returned to the requester |

## Verification
The case that matters most is when the second beat of a split word access and the taking of the next request fall on the same clock edge. The bench starts a word write to SDRAM and, during its first beat, presents a peripheral word read. It then checks three things: req_ready is low in the first beat and high in the second, both beats carry the right halves and offsets, and the held request appears right after the second beat with its own one-beat decode. A split read of an unmapped region is also checked beat by beat while the target data lines are driven high.

// File: rtl/rgn_dec_pkg.sv
package rgn_dec_pkg;
  localparam int NUM_TGT  = 11;
  localparam int T_BOOT0  = 0;
  localparam int T_BOOT1  = 1;
  localparam int T_SYSREG = 2;
  localparam int T_VIDREG = 3;
  localparam int T_PAL    = 4;
  localparam int T_CART   = 5;
  localparam int T_FBUF   = 6;
  localparam int T_SDRAM  = 7;
  localparam int T_DARR0  = 8;
  localparam int T_DARR1  = 9;
  localparam int T_PERIPH = 10;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [4:0] IDX_DARR   = 5'h18;
  localparam logic [4:0] IDX_PERIPH = 5'h1F;

  // coarse region: three top bits joined with the two chip-select bits
  function automatic logic [4:0] region_index(input logic [31:0] a);
    return {a[31:29], a[26:25]};
  endfunction
endpackage

// File: rtl/rgn_req_stage.sv
module rgn_req_stage
  import rgn_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_cpu,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        beat_valid,
  output logic        beat_cpu,
  output logic        beat_write,
  output logic [1:0]  beat_size,
  output logic [31:0] beat_addr,
  output logic [31:0] beat_wdata,
  output logic        split_busy
);
  logic        v_q, v_d, ph_q, ph_d;
  logic        cpu_q, wr_q;
  logic [1:0]  size_q;
  logic [31:0] addr_q, wdata_q;
  logic        take, split, base_periph;

  assign base_periph = (region_index(addr_q) == IDX_PERIPH);
  assign split       = v_q & size_q[1] & ~base_periph;
  assign req_ready   = ~split | ph_q;
  assign take        = req_valid & req_ready;

  always_comb begin
    v_d  = v_q;
    ph_d = ph_q;
    if (take) begin
      v_d  = 1'b1;
      ph_d = 1'b0;
    end else if (split && !ph_q) begin
      ph_d = 1'b1;
    end else begin
      v_d  = 1'b0;
      ph_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      v_q  <= v_d;
      ph_q <= ph_d;
    end
  end

  // payload loads only on an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q   <= 1'b0;
      wr_q    <= 1'b0;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      cpu_q   <= req_cpu;
      wr_q    <= req_write;
      size_q  <= req_size;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign beat_valid = v_q;
  assign beat_cpu   = cpu_q;
  assign beat_write = wr_q;
  assign beat_size  = split ? SZ_HALF : size_q;
  assign beat_addr  = ph_q ? (addr_q + 32'd2) : addr_q;
  assign beat_wdata = split ? {16'h0000, (ph_q ? wdata_q[15:0] : wdata_q[31:16])}
                            : wdata_q;
  assign split_busy = split;
endmodule

// File: rtl/rgn_cs0_decode.sv
module rgn_cs0_decode #(
  parameter int          BOOT_BYTES = 2048,
  parameter logic [9:0]  SYS_WIN    = 10'h040,
  parameter logic [9:0]  VID_WIN    = 10'h041,
  parameter logic [9:0]  PAL_WIN    = 10'h042
) (
  input  logic [28:0] addr,
  input  logic        cpu,
  input  logic        write,
  output logic [4:0]  sel,
  output logic [31:0] ofs
);
  localparam logic [31:0] BOOT_MASK = 32'(BOOT_BYTES - 1);
  localparam logic [31:0] BOOT_LIM  = 32'(BOOT_BYTES);

  logic [31:0] a32;
  logic        hit_sys, hit_vid, hit_pal, hit_boot;

  assign a32      = {3'b000, addr};
  assign hit_sys  = (addr[17:8] == SYS_WIN);
  assign hit_vid  = (addr[17:8] == VID_WIN);
  assign hit_pal  = write ? (addr[17:9] == PAL_WIN[9:1]) : (addr[17:8] == PAL_WIN);
  assign hit_boot = (a32 < BOOT_LIM);

  // register windows take priority over the boot ROM
  always_comb begin
    sel = 5'b00000;
    ofs = '0;
    if (hit_sys) begin
      sel[2] = 1'b1;
      ofs    = a32 & 32'h0000_00FF;
    end else if (hit_vid) begin
      sel[3] = 1'b1;
      ofs    = a32 & 32'h0000_00FF;
    end else if (hit_pal) begin
      sel[4] = 1'b1;
      ofs    = a32 & 32'h0000_01FF;
    end else if (hit_boot) begin
      sel[cpu ? 1 : 0] = 1'b1;
      ofs              = a32 & BOOT_MASK;
    end
  end
endmodule

// File: rtl/rgn_region_decode.sv
module rgn_region_decode
  import rgn_dec_pkg::*;
#(
  parameter int          BOOT_BYTES  = 2048,
  parameter logic [31:0] CART_MASK   = 32'h003F_FFFF,
  parameter logic [31:0] FB_MASK     = 32'h0001_FFFF,
  parameter logic [31:0] SDRAM_MASK  = 32'h0003_FFFF,
  parameter int          DARR_BITS   = 12,
  parameter int          PERIPH_BITS = 9
) (
  input  logic               valid,
  input  logic [31:0]        addr,
  input  logic               cpu,
  input  logic               write,
  input  logic [1:0]         size,
  output logic [NUM_TGT-1:0] sel,
  output logic [31:0]        ofs,
  output logic               unmapped
);
  localparam logic [31:0] DARR_MASK = (32'd1 << DARR_BITS) - 32'd1;
  localparam logic [31:0] PER_MASK  = (32'd1 << PERIPH_BITS) - 32'd1;

  logic [4:0]         idx;
  logic [4:0]         cs0_sel;
  logic [31:0]        cs0_ofs, raw;
  logic [NUM_TGT-1:0] hit;

  assign idx = region_index(addr);

  rgn_cs0_decode #(.BOOT_BYTES(BOOT_BYTES)) u_cs0 (
    .addr (addr[28:0]),
    .cpu  (cpu),
    .write(write),
    .sel  (cs0_sel),
    .ofs  (cs0_ofs)
  );

  always_comb begin
    hit = '0;
    raw = '0;
    case (idx)
      5'd0, 5'd4: begin
        hit[4:0] = cs0_sel;
        raw      = cs0_ofs;
      end
      5'd1, 5'd5: begin
        hit[T_CART] = 1'b1;
        raw         = addr & CART_MASK;
      end
      5'd2, 5'd6: begin
        hit[T_FBUF] = 1'b1;
        raw         = addr & FB_MASK;
      end
      5'd3, 5'd7: begin
        hit[T_SDRAM] = 1'b1;
        raw          = addr & SDRAM_MASK;
      end
      IDX_DARR: begin
        hit[cpu ? T_DARR1 : T_DARR0] = 1'b1;
        raw                          = addr & DARR_MASK;
      end
      IDX_PERIPH: begin
        hit[T_PERIPH] = 1'b1;
        raw           = addr & PER_MASK;
      end
      default: begin
        hit = '0;
        raw = '0;
      end
    endcase
  end

  // halfword-organised targets: swap byte lane, align halfwords
  always_comb begin
    sel      = '0;
    ofs      = '0;
    unmapped = 1'b0;
    if (valid) begin
      sel      = hit;
      unmapped = (hit == '0);
      ofs      = raw;
      if (!hit[T_PERIPH] && hit != '0) begin
        if (size == SZ_BYTE) ofs[0] = ~raw[0];
        else                 ofs[0] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rgn_bus_decoder.sv
module rgn_bus_decoder
  import rgn_dec_pkg::*;
#(
  parameter int          BOOT_BYTES  = 2048,
  parameter int          OFS_W       = 22,
  parameter logic [31:0] CART_MASK   = 32'h003F_FFFF,
  parameter logic [31:0] FB_MASK     = 32'h0001_FFFF,
  parameter logic [31:0] SDRAM_MASK  = 32'h0003_FFFF,
  parameter int          DARR_BITS   = 12,
  parameter int          PERIPH_BITS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_cpu,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  output logic               acc_valid,
  output logic               acc_cpu,
  output logic               acc_write,
  output logic [1:0]         acc_size,
  output logic [NUM_TGT-1:0] acc_sel,
  output logic [OFS_W-1:0]   acc_offset,
  output logic [31:0]        acc_wdata,
  output logic               acc_unmapped,
  output logic               acc_busy,
  input  logic [31:0]        tgt_rdata,
  output logic [31:0]        rsp_data
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [31:0] beat_addr, ofs_full;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rgn_req_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cpu   (req_cpu),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .beat_valid(acc_valid),
    .beat_cpu  (acc_cpu),
    .beat_write(acc_write),
    .beat_size (acc_size),
    .beat_addr (beat_addr),
    .beat_wdata(acc_wdata),
    .split_busy(acc_busy)
  );

  rgn_region_decode #(
    .BOOT_BYTES (BOOT_BYTES),
    .CART_MASK  (CART_MASK),
    .FB_MASK    (FB_MASK),
    .SDRAM_MASK (SDRAM_MASK),
    .DARR_BITS  (DARR_BITS),
    .PERIPH_BITS(PERIPH_BITS)
  ) u_dec (
    .valid   (acc_valid),
    .addr    (beat_addr),
    .cpu     (acc_cpu),
    .write   (acc_write),
    .size    (acc_size),
    .sel     (acc_sel),
    .ofs     (ofs_full),
    .unmapped(acc_unmapped)
  );

  assign acc_offset = ofs_full[OFS_W-1:0];
  assign rsp_data   = acc_unmapped ? 32'h0 : tgt_rdata;
endmodule

// File: rtl/rgn_bus_decoder_chk.sv
module rgn_bus_decoder_chk
  import rgn_dec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               acc_valid,
  input logic               acc_cpu,
  input logic               acc_write,
  input logic [1:0]         acc_size,
  input logic [NUM_TGT-1:0] acc_sel,
  input logic               acc_unmapped,
  input logic               acc_busy
);
  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot0(acc_sel));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_sel == '0 && !acc_unmapped && !acc_busy));

  p_unmapped_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_unmapped |-> (acc_valid && acc_sel == '0));

  p_second_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && !req_ready) |=>
      (acc_valid && acc_busy && req_ready && acc_size == SZ_HALF &&
       acc_write == $past(acc_write) && acc_cpu == $past(acc_cpu)));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (acc_busy && acc_valid));

  p_word_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == SZ_WORD) |-> acc_sel[T_PERIPH]);

  p_owner_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel[T_DARR1] || acc_sel[T_BOOT1]) |-> acc_cpu);

  p_owner_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel[T_DARR0] || acc_sel[T_BOOT0]) |-> !acc_cpu);
endmodule

bind rgn_bus_decoder rgn_bus_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .acc_valid   (acc_valid),
  .acc_cpu     (acc_cpu),
  .acc_write   (acc_write),
  .acc_size    (acc_size),
  .acc_sel     (acc_sel),
  .acc_unmapped(acc_unmapped),
  .acc_busy    (acc_busy)
);

// File: tb/rgn_bus_decoder_test.sv
module rgn_bus_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_cpu, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        acc_valid, acc_cpu, acc_write, acc_unmapped, acc_busy;
  logic [1:0]  acc_size;
  logic [10:0] acc_sel;
  logic [21:0] acc_offset;
  logic [31:0] acc_wdata, tgt_rdata, rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rgn_bus_decoder uut (.*);

  // {cpu, write, size, addr, expected sel, expected offset, expected unmapped}
  localparam int NV = 20;
  localparam logic [69:0] TBL [0:NV-1] = '{
    {1'b0,1'b0,2'd1,32'h0212_3456,11'h020,22'h123456,1'b0}, // R1 cart
    {1'b0,1'b0,2'd0,32'h2212_3457,11'h020,22'h123456,1'b0}, // R1 alias, R6 byte
    {1'b0,1'b0,2'd1,32'h0403_FFFE,11'h040,22'h01FFFE,1'b0}, // R1 frame buffer
    {1'b1,1'b1,2'd0,32'h2400_0010,11'h040,22'h000011,1'b0}, // R1 alias, R6
    {1'b0,1'b0,2'd1,32'h0607_FFFC,11'h080,22'h03FFFC,1'b0}, // R1 sdram
    {1'b0,1'b1,2'd1,32'h2600_1001,11'h080,22'h001000,1'b0}, // R6 half clears bit0
    {1'b0,1'b0,2'd1,32'hC000_0ABC,11'h100,22'h000ABC,1'b0}, // R2 cpu0
    {1'b1,1'b1,2'd0,32'hC000_0ABD,11'h200,22'h000ABC,1'b0}, // R2 cpu1
    {1'b0,1'b0,2'd1,32'h0000_4012,11'h004,22'h000012,1'b0}, // R3 sys
    {1'b1,1'b0,2'd0,32'h2000_4101,11'h008,22'h000000,1'b0}, // R3 video
    {1'b0,1'b0,2'd1,32'h0000_4234,11'h010,22'h000034,1'b0}, // R3 palette read
    {1'b0,1'b1,2'd1,32'h0000_43FE,11'h010,22'h0001FE,1'b0}, // R3 palette write 0x43
    {1'b0,1'b0,2'd1,32'h0000_4300,11'h000,22'h000000,1'b1}, // R3 read 0x43 unmapped
    {1'b0,1'b0,2'd1,32'h0000_0100,11'h001,22'h000100,1'b0}, // R4 boot cpu0
    {1'b1,1'b0,2'd0,32'h2000_07FF,11'h002,22'h0007FE,1'b0}, // R4 boot cpu1
    {1'b0,1'b0,2'd1,32'h0000_0800,11'h000,22'h000000,1'b1}, // R4 boundary
    {1'b0,1'b1,2'd1,32'h4000_0000,11'h000,22'h000000,1'b1}, // R5 index 8
    {1'b0,1'b0,2'd0,32'hFFFF_FE05,11'h400,22'h000005,1'b0}, // R9 R6 periph byte
    {1'b1,1'b0,2'd1,32'hFFFF_FF12,11'h400,22'h000112,1'b0}, // R9 periph half
    {1'b0,1'b0,2'd1,32'hFC00_0000,11'h000,22'h000000,1'b1}  // R5 index 0x1E
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] d);
    req_cpu = c; req_write = w; req_size = s; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cpu = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0; tgt_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 64'(acc_valid), 64'd0);
    chk("R11 reset sel", 64'(acc_sel), 64'd0);
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset busy", 64'(acc_busy), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle unmapped", 64'(acc_unmapped), 64'd0);
    chk("R11 idle ready", 64'(req_ready), 64'd1);

    // decode table (R1 R2 R3 R4 R5 R6 R9)
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][69], TBL[i][68], TBL[i][67:66], TBL[i][65:34], 32'h0);
      @(negedge clk);
      chk($sformatf("R1 table %0d sel", i), 64'(acc_sel), 64'(TBL[i][33:23]));
      chk($sformatf("R6 table %0d offset", i), 64'(acc_offset), 64'(TBL[i][22:1]));
      chk($sformatf("R5 table %0d unmapped", i), 64'(acc_unmapped), 64'(TBL[i][0]));
      chk($sformatf("R10 table %0d size", i), 64'(acc_size), 64'(TBL[i][67:66]));
      chk($sformatf("R2 table %0d cpu", i), 64'(acc_cpu), 64'(TBL[i][69]));
      req_valid = 1'b0;
    end

    // R10: single beat lasts one cycle
    drive(1'b0, 1'b0, 2'd1, 32'h0600_0020, 32'h0);
    @(negedge clk); req_valid = 1'b0;
    chk("R10 beat valid", 64'(acc_valid), 64'd1);
    @(negedge clk);
    chk("R10 one cycle", 64'(acc_valid), 64'd0);

    // R7 R8: split sdram write with a request held during beat one
    drive(1'b0, 1'b1, 2'd2, 32'h0600_0010, 32'hAABB_CCDD);
    @(negedge clk);
    chk("R7 beat0 sel", 64'(acc_sel), 64'h080);
    chk("R7 beat0 offset", 64'(acc_offset), 64'h10);
    chk("R7 beat0 size", 64'(acc_size), 64'd1);
    chk("R7 beat0 data", 64'(acc_wdata), 64'h0000_AABB);
    chk("R8 beat0 busy", 64'(acc_busy), 64'd1);
    chk("R8 beat0 ready", 64'(req_ready), 64'd0);
    drive(1'b1, 1'b0, 2'd2, 32'hFFFF_FE10, 32'h0);
    @(negedge clk);
    chk("R7 beat1 offset", 64'(acc_offset), 64'h12);
    chk("R7 beat1 data", 64'(acc_wdata), 64'h0000_CCDD);
    chk("R7 beat1 write", 64'(acc_write), 64'd1);
    chk("R8 beat1 busy", 64'(acc_busy), 64'd1);
    chk("R8 beat1 ready", 64'(req_ready), 64'd1);
    @(negedge clk); req_valid = 1'b0;
    chk("R8 held request sel", 64'(acc_sel), 64'h400);
    chk("R9 word size", 64'(acc_size), 64'd2);
    chk("R9 word offset", 64'(acc_offset), 64'h010);
    chk("R9 no busy", 64'(acc_busy), 64'd0);
    chk("R8 held request cpu", 64'(acc_cpu), 64'd1);

    // R9: peripheral word write passes full data
    drive(1'b0, 1'b1, 2'd2, 32'hFFFF_FE20, 32'h1234_5678);
    @(negedge clk); req_valid = 1'b0;
    chk("R9 full data", 64'(acc_wdata), 64'h1234_5678);
    chk("R9 ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk("R9 single beat", 64'(acc_valid), 64'd0);

    // R5: unmapped split read returns zero on both beats
    tgt_rdata = 32'hFFFF_FFFF;
    drive(1'b0, 1'b0, 2'd2, 32'h4000_0000, 32'h0);
    @(negedge clk); req_valid = 1'b0;
    chk("R5 beat0 unmapped", 64'(acc_unmapped), 64'd1);
    chk("R5 beat0 rsp", 64'(rsp_data), 64'd0);
    chk("R7 unmapped split busy", 64'(acc_busy), 64'd1);
    @(negedge clk);
    chk("R5 beat1 unmapped", 64'(acc_unmapped), 64'd1);
    chk("R5 beat1 rsp", 64'(rsp_data), 64'd0);
    drive(1'b0, 1'b0, 2'd1, 32'h0200_0000, 32'h0);
    @(negedge clk); req_valid = 1'b0;
    chk("R5 mapped rsp", 64'(rsp_data), 64'hFFFF_FFFF);

    // R2 R7: split read of processor 1 data array
    drive(1'b1, 1'b0, 2'd2, 32'hC000_0100, 32'h0);
    @(negedge clk); req_valid = 1'b0;
    chk("R2 split beat0 sel", 64'(acc_sel), 64'h200);
    chk("R7 split beat0 offset", 64'(acc_offset), 64'h100);
    @(negedge clk);
    chk("R7 split beat1 offset", 64'(acc_offset), 64'h102);
    chk("R2 split beat1 sel", 64'(acc_sel), 64'h200);
    @(negedge clk);
    chk("R10 split ends", 64'(acc_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule